// File: doc/BRIEF.md
# Serial Character Receiver with Held Parity Flag

This block receives asynchronous serial characters on a single input line and turns each one into a parallel word. The line rests high. A character is a low start bit, eight data bits with the least significant first, one even-parity bit and a high stop bit. Each bit lasts `CLKS_PER_BIT` clock cycles; the bit timing comes from an internal counter with that constant divisor. After a falling edge, the block checks the line again half a bit later to confirm the start. It then samples each later bit in the middle of its bit time.

The bits are shifted into a collecting register. A separate transfer state copies that register into a holding register, and a completion state follows. The held character drives the low byte of a 16-bit output, and the upper byte is zero. A buffer-full flag announces the new character. A parity flag records whether that character passed the even-parity check. The parity flag keeps its value until reset or until the next character completes, so a fault stays visible while the following character is still arriving.

Top module: `serial_char_rx`

## Requirements
- R1: While `rst_n` is low, and right after it rises, `data_out`, `buffer_full` and `parity_error` are all 0.
- R2: For a frame of a start bit (0), eight data bits least significant first, a parity bit and a stop bit (1), each bit `CLKS_PER_BIT` cycles wide, the data byte appears on `data_out[7:0]` in the cycle in which `buffer_full` rises.
- R3: `data_out[15:8]` is always 0, and `data_out` changes only in a cycle in which `buffer_full` rises.
- R4: `buffer_full` goes to 1 when a character completes. It stays 1 until the start bit of the next character is confirmed at the half-bit check, or until reset.
- R5: One cycle after `buffer_full` rises, `parity_error` equals the XOR of the eight data bits and the received parity bit (1 means the parity is wrong under even parity).
- R6: `parity_error` holds its value while the next character is being received and changes only when that character completes. Reset clears it.
- R7: A low pulse on the line that reads high again at the half-bit check is discarded: `data_out`, `buffer_full` and `parity_error` do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous master reset, active low |
| rx_line | input | 1 | Serial input line, idles high |
| data_out | output | 16 | Received character in bits 7:0, zero in bits 15:8 |
| buffer_full | output | 1 | A completed character is being held |
| parity_error | output | 1 | The last completed character failed the even-parity check (held) |

## Verification
The bench builds the receiver with `CLKS_PER_BIT` = 8. At that divisor a whole frame lasts 88 cycles. This makes it practical to send all 256 byte values twice, once with correct parity and once with the parity bit inverted. Part-way through every frame the bench checks that `buffer_full` has been cleared and that `parity_error` still shows the previous result. The short bit time also lets a three-cycle glitch fall well short of the half-bit check, so the glitch case is exercised just after a bad-parity character, while the held flags are both set.

// File: rtl/serial_char_rx_pkg.sv
// Shared types for the serial character receiver.
package serial_char_rx_pkg;

    // Control sequence: hunt, start check, data, parity, stop, transfer, complete.
    typedef enum logic [2:0] {
        ST_HUNT   = 3'd0,
        ST_START  = 3'd1,
        ST_DATA   = 3'd2,
        ST_PARITY = 3'd3,
        ST_STOP   = 3'd4,
        ST_XFER   = 3'd5,
        ST_DONE   = 3'd6
    } rx_state_e;

endpackage

// File: rtl/rx_line_sync.sv
// Two-flop synchroniser for the serial line, followed by falling-edge detection.
// Assumes the line idles high; all registers reset to the idle level.
module rx_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_s,
    output logic fall
);
    logic meta_q;
    logic prev_q;

    // Bring the asynchronous line into the clock domain and keep one older sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            line_s <= 1'b1;
            prev_q <= 1'b1;
        end else begin
            meta_q <= line_in;
            line_s <= meta_q;
            prev_q <= line_s;
        end
    end

    // A high-to-low step of the synchronised line.
    assign fall = prev_q & ~line_s;
endmodule

// File: rtl/rx_bit_timer.sv
// Counts cycles within a bit period. tick pulses after HALF_BIT cycles when
// half_sel is set, otherwise after CLKS_PER_BIT cycles. clr holds it at zero.
// Assumes CLKS_PER_BIT >= 4.
module rx_bit_timer #(
    parameter int CLKS_PER_BIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic half_sel,
    output logic tick
);
    localparam int HALF_BIT = CLKS_PER_BIT / 2;
    localparam int CNT_W    = $clog2(CLKS_PER_BIT);

    logic [CNT_W-1:0] cnt_q;

    assign tick = !clr && (cnt_q == (half_sel ? CNT_W'(HALF_BIT - 1)
                                              : CNT_W'(CLKS_PER_BIT - 1)));

    // Free-running count, restarted on clear and after each tick.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/rx_ctrl.sv
// Control state machine: hunts for a start edge, confirms it at half a bit,
// steps through data, parity and stop bits at each tick, then transfer and
// completion states. Emits strobes for the datapath in the top module.
module rx_ctrl
    import serial_char_rx_pkg::*;
#(
    parameter int DATA_BITS = 8
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      line_s,
    input  logic      fall,
    input  logic      tick,
    output logic      timer_clr,
    output logic      half_sel,
    output logic      start_ok,
    output logic      shift_en,
    output logic      par_en,
    output rx_state_e state
);
    localparam int IDX_W = $clog2(DATA_BITS);

    rx_state_e        nxt;
    logic [IDX_W-1:0] idx_q;

    assign timer_clr = (state == ST_HUNT);
    assign half_sel  = (state == ST_START);
    assign start_ok  = (state == ST_START) && tick && !line_s;
    assign shift_en  = (state == ST_DATA) && tick;
    assign par_en    = (state == ST_PARITY) && tick;

    // Next-state selection.
    always_comb begin
        nxt = state;
        case (state)
            ST_HUNT:   if (fall) nxt = ST_START;
            ST_START:  if (tick) nxt = line_s ? ST_HUNT : ST_DATA;
            ST_DATA:   if (tick && idx_q == IDX_W'(DATA_BITS - 1)) nxt = ST_PARITY;
            ST_PARITY: if (tick) nxt = ST_STOP;
            ST_STOP:   if (tick) nxt = ST_XFER;
            ST_XFER:   nxt = ST_DONE;
            ST_DONE:   nxt = ST_HUNT;
            default:   nxt = ST_HUNT;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_HUNT;
        else        state <= nxt;
    end

    // Data bit index, zeroed at each confirmed start.
    always_ff @(posedge clk) begin
        if (!rst_n || start_ok) idx_q <= '0;
        else if (shift_en)      idx_q <= idx_q + 1'b1;
    end
endmodule

// File: rtl/serial_char_rx.sv
// Serial character receiver top. Holds the datapath: a collecting shift
// register, a holding register loaded in the transfer state, the buffer-full
// flag and the held parity flag. The parity flop is enabled by buffer_full.
// Assumes one start bit, DATA_BITS data bits LSB first, even parity, one stop.
module serial_char_rx
    import serial_char_rx_pkg::*;
#(
    parameter int CLKS_PER_BIT = 16,
    parameter int DATA_BITS    = 8,
    parameter int OUT_W        = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_line,
    output logic [OUT_W-1:0] data_out,
    output logic             buffer_full,
    output logic             parity_error
);
    logic                 line_s, fall, tick;
    logic                 timer_clr, half_sel, start_ok, shift_en, par_en;
    rx_state_e            rx_state;
    logic [DATA_BITS-1:0] shift_q;
    logic [DATA_BITS-1:0] hold_q;
    logic                 par_shift_q;
    logic                 par_hold_q;

    rx_line_sync i_sync (
        .clk(clk), .rst_n(rst_n), .line_in(rx_line), .line_s(line_s), .fall(fall)
    );

    rx_bit_timer #(.CLKS_PER_BIT(CLKS_PER_BIT)) i_timer (
        .clk(clk), .rst_n(rst_n), .clr(timer_clr), .half_sel(half_sel), .tick(tick)
    );

    rx_ctrl #(.DATA_BITS(DATA_BITS)) i_ctrl (
        .clk(clk), .rst_n(rst_n), .line_s(line_s), .fall(fall), .tick(tick),
        .timer_clr(timer_clr), .half_sel(half_sel), .start_ok(start_ok),
        .shift_en(shift_en), .par_en(par_en), .state(rx_state)
    );

    // Collect data bits LSB first and capture the parity bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q     <= '0;
            par_shift_q <= 1'b0;
        end else begin
            if (shift_en) shift_q     <= {line_s, shift_q[DATA_BITS-1:1]};
            if (par_en)   par_shift_q <= line_s;
        end
    end

    // Transfer state: copy the collected character into the holding register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q     <= '0;
            par_hold_q <= 1'b0;
        end else if (rx_state == ST_XFER) begin
            hold_q     <= shift_q;
            par_hold_q <= par_shift_q;
        end
    end

    // Buffer-full: set entering completion, cleared by a confirmed start.
    always_ff @(posedge clk) begin
        if (!rst_n)                    buffer_full <= 1'b0;
        else if (rx_state == ST_XFER)  buffer_full <= 1'b1;
        else if (start_ok)             buffer_full <= 1'b0;
    end

    // Parity flop, loaded only while buffer_full is high; holds otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)           parity_error <= 1'b0;
        else if (buffer_full) parity_error <= (^hold_q) ^ par_hold_q;
    end

    // Character in the low bits, zero above.
    generate
        if (OUT_W > DATA_BITS) begin : g_pad
            assign data_out = {{(OUT_W - DATA_BITS){1'b0}}, hold_q};
        end else begin : g_trunc
            assign data_out = hold_q[OUT_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/serial_char_rx_chk.sv
// Checker for the serial character receiver, attached with bind.
module serial_char_rx_chk
    import serial_char_rx_pkg::*;
#(
    parameter int OUT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [OUT_W-1:0] data_out,
    input logic             buffer_full,
    input logic             parity_error,
    input rx_state_e        rx_state
);
    // R3
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(buffer_full) |-> $stable(data_out));

    // R6
    parity_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(parity_error) |-> $past(buffer_full));

    // R4
    full_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(buffer_full) |-> $past(rx_state == ST_XFER));

    // R4
    full_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(buffer_full) |-> $past(rx_state == ST_START));

    // R4
    done_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_state == ST_DONE) |-> buffer_full);
endmodule

bind serial_char_rx serial_char_rx_chk #(.OUT_W(OUT_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .data_out(data_out), .buffer_full(buffer_full),
    .parity_error(parity_error), .rx_state(rx_state)
);

// File: tb/test_serial_char_rx.sv
// Bench: all byte values with good and bad parity, glitch and reset cases.
module test_serial_char_rx;
    localparam int CPB   = 8;
    localparam int OUT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             rx_line = 1'b1;
    logic [OUT_W-1:0] data_out;
    logic             buffer_full;
    logic             parity_error;

    int  checks = 0;
    int  errors = 0;
    bit  finished = 0;
    logic prev_perr = 1'b0;

    always #4 clk = ~clk;

    serial_char_rx #(.CLKS_PER_BIT(CPB), .DATA_BITS(8), .OUT_W(OUT_W)) i_serial_char_rx (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_line),
        .data_out(data_out), .buffer_full(buffer_full), .parity_error(parity_error)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Drive one frame; check mid-frame held state, then results after an idle bit.
    task automatic send(input logic [7:0] b, input bit bad);
        logic [10:0] bits;
        bits = {1'b1, (^b) ^ bad, b, 1'b0};
        for (int k = 0; k < 11; k++) begin
            rx_line = bits[k];
            if (k == 5) begin
                wait_cycles(CPB / 2);
                check("R4 cleared mid-frame", {31'd0, buffer_full}, 32'd0);
                check("R6 parity held mid-frame", {31'd0, parity_error}, {31'd0, prev_perr});
                wait_cycles(CPB - CPB / 2);
            end else begin
                wait_cycles(CPB);
            end
        end
        rx_line = 1'b1;
        wait_cycles(CPB);
        check("R4 buffer_full set", {31'd0, buffer_full}, 32'd1);
        check("R2 data byte", {16'd0, data_out}, {24'd0, b});
        check("R3 upper zero", {24'd0, data_out[15:8]}, 32'd0);
        check("R5 parity result", {31'd0, parity_error}, {31'd0, bad});
        prev_perr = bad;
    endtask

    initial begin
        wait_cycles(4);
        check("R1 reset data", {16'd0, data_out}, 32'd0);
        check("R1 reset full", {31'd0, buffer_full}, 32'd0);
        check("R1 reset parity", {31'd0, parity_error}, 32'd0);
        rst_n = 1'b1;
        wait_cycles(2 * CPB);
        check("R1 after reset", {15'd0, data_out, buffer_full, parity_error}, 32'd0);

        for (int v = 0; v < 256; v++) begin
            send(8'(v), 1'b0);
            send(8'(v ^ 8'hA5), 1'b1);
        end

        // R7: glitch after a bad-parity character; both flags set.
        rx_line = 1'b0;
        wait_cycles(3);
        rx_line = 1'b1;
        wait_cycles(3 * CPB);
        check("R7 glitch full", {31'd0, buffer_full}, 32'd1);
        check("R7 glitch parity", {31'd0, parity_error}, 32'd1);
        check("R7 glitch data", {16'd0, data_out}, {24'd0, 8'hFF ^ 8'hA5});

        // R6: a good character after the glitch clears the held flag.
        send(8'h3C, 1'b0);

        // R6 / R1: reset clears a set parity flag.
        send(8'h81, 1'b1);
        rst_n = 1'b0;
        wait_cycles(2);
        check("R6 reset clears parity", {31'd0, parity_error}, 32'd0);
        check("R1 reset clears full", {31'd0, buffer_full}, 32'd0);
        check("R1 reset clears data", {16'd0, data_out}, 32'd0);
        rst_n = 1'b1;
        wait_cycles(4);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule